// File: doc/BRIEF.md
# Password and Pointer Protection Controller

This block is the access gate in front of a small protected non-volatile array. It keeps a secret code of one to eight bytes together with its length, a boundary pointer that divides the address space into a lower and an upper region, and four flags:

- access granted
- access locked out
- programming armed
- one-shot pointer override

A command decoder upstream delivers command events and their payload bytes. For every memory request the block combines the address and the kind of access with this state and answers allow or deny in the same cycle.

When the stored length is zero the array is open. Reads are always allowed, and writes are allowed only above the pointer once programming is armed. A non-zero length switches to the secure mode. The upper region becomes read-only, and the lower region is unreachable until the correct code has been presented. Code changes take the old code and then the new code twice. A pointer override opens the lower region for exactly one committed program or erase.

The stored state is held in plain registers that model the non-volatile cells. A frame abort, which is the chip-select reset, only discards a partly received command.

Top module: `pwd_guard`

## Requirements
- R1: After reset the code length is zero and the pointer is zero. Reads (req_kind 0) of every address are allowed, and programming is disarmed.
- R2: Single program/erase requests (req_kind 1) and whole-array requests (req_kind 2) are denied unless programming is armed by cmd_op 5. Command cmd_op 6 disarms it again.
- R3: With length zero, addresses below the pointer allow reads only. Addresses at or above the pointer also allow single program/erase when programming is armed.
- R4: Code change (cmd_op 0) takes these bytes in order: a length byte, then the old code (stored-length bytes, sent only when the stored length is non-zero), then the new code, then the new code again. The new code and length are taken only if the old code matched and both copies agree; otherwise nothing changes.
- R5: A code-change length byte above 8 is illegal. The controller ignores every following byte until the next command.
- R6: With a non-zero length and no granted access, every request below the pointer is denied. At or above the pointer reads are allowed and program/erase is denied. After a successful access grant both regions follow the R3 rules.
- R7: Access grant (cmd_op 1) compares exactly the stored number of payload bytes. The result takes effect only after the last byte. A mismatch leaves access not granted.
- R8: Pointer override (cmd_op 4) allows exactly one committed single program/erase (req_commit high on a granted req_kind 1) below the pointer. In the secure mode it is ignored unless access is granted.
- R9: Pointer write (cmd_op 3) takes ceil(AW/8) bytes, most significant first. In the secure mode it is ignored unless access is granted.
- R10: Access lock (cmd_op 2) denies all single and whole-array program/erase, whatever the pointer, and withdraws granted access. Only a successful grant clears it.
- R11: Whole-array requests ignore the pointer. They need armed programming, no lock and, in the secure mode, granted access.
- R12: frame_abort drops a partly received command but keeps the grant, lock and programming flags.
- R13: A code change to length 0 with the correct old code returns to the open mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low power-on reset |
| frame_abort | input | 1 | chip-select reset: abandon the current command |
| cmd_valid | input | 1 | a new command event starts this cycle |
| cmd_op | input | 3 | 0 code change, 1 grant, 2 lock, 3 pointer write, 4 override, 5 arm, 6 disarm |
| byte_valid | input | 1 | payload byte present |
| byte_data | input | 8 | payload byte |
| req_addr | input | AW | address of the request |
| req_kind | input | 2 | 0 read, 1 single program/erase, 2 whole array, 3 none |
| req_commit | input | 1 | the request is carried out this cycle |
| req_allow | output | 1 | request is permitted |

## Verification
The bench goes after the one-shot override. A design that forgot to clear it after the committed write would leave the lower region writable for good, and the second write below the pointer would come back allowed.

It feeds a code change whose two copies differ, one whose old code is wrong, and one with an illegal length. A design that took any of these would turn secure, or take on a code that later grants fail against.

It issues pointer writes and overrides without granted access in the secure mode. A design that obeyed them would move the boundary or open the lower region, and that shows up later as a wrongly allowed write. Aborts in the middle of a grant and of a code change must leave the flags and the stored code untouched.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [2:0] {
    OP_MODIFY   = 3'd0,
    OP_GRANT    = 3'd1,
    OP_LOCK     = 3'd2,
    OP_WPTR     = 3'd3,
    OP_OVERRIDE = 3'd4,
    OP_ARM      = 3'd5,
    OP_DISARM   = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    AK_READ = 2'd0,
    AK_ONE  = 2'd1,
    AK_BULK = 2'd2,
    AK_NONE = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_MLEN, SQ_MOLD, SQ_NEW1, SQ_NEW2, SQ_GRANT, SQ_PTR, SQ_SKIP
  } seq_e;
endpackage

// File: rtl/pg_seq.sv
module pg_seq
  import pg_pkg::*;
#(
  parameter int AW      = 9,
  parameter int MAX_LEN = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              frame_abort,
  input  logic                              cmd_valid,
  input  logic [2:0]                        cmd_op,
  input  logic                              byte_valid,
  input  logic [7:0]                        byte_data,
  output logic [$clog2(MAX_LEN+1)-1:0]      len_q,
  output logic                              ev_ok,
  output logic                              ev_fail,
  output logic                              ev_ptr,
  output logic [AW-1:0]                     ptr_val
);
  localparam int LW  = $clog2(MAX_LEN + 1);
  localparam int IW  = $clog2(MAX_LEN);
  localparam int PB  = (AW + 7) / 8;
  localparam int PBW = PB * 8;

  seq_e            st_q, st_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic            bad_q, bad_d;
  logic [LW-1:0]   nlen_q, nlen_d;
  logic [PBW-1:0]  pacc_q, pacc_d;
  logic [7:0]      code_q  [MAX_LEN];
  logic [7:0]      stage_q [MAX_LEN];
  logic            commit, stage_we;
  logic            old_miss, cpy_miss, last_old, last_new, last_ptr;

  always_comb begin
    st_d = st_q; idx_d = idx_q; bad_d = bad_q; nlen_d = nlen_q; pacc_d = pacc_q;
    ev_ok = 1'b0; ev_fail = 1'b0; ev_ptr = 1'b0; commit = 1'b0; stage_we = 1'b0;
    old_miss = (byte_data != code_q[idx_q]);
    cpy_miss = (byte_data != stage_q[idx_q]);
    last_old = (LW'(idx_q) == len_q - LW'(1));
    last_new = (LW'(idx_q) == nlen_q - LW'(1));
    last_ptr = (idx_q == IW'(PB - 1));
    if (frame_abort) begin
      st_d = SQ_IDLE;
    end else if (cmd_valid) begin
      idx_d = '0; bad_d = 1'b0; pacc_d = '0;
      case (op_e'(cmd_op))
        OP_MODIFY: st_d = SQ_MLEN;
        OP_GRANT: begin
          if (len_q == '0) begin ev_ok = 1'b1; st_d = SQ_IDLE; end
          else st_d = SQ_GRANT;
        end
        OP_WPTR: st_d = SQ_PTR;
        default: st_d = SQ_IDLE;
      endcase
    end else if (byte_valid) begin
      idx_d = idx_q + IW'(1);
      case (st_q)
        SQ_MLEN: begin
          idx_d = '0;
          if (byte_data > 8'(MAX_LEN)) st_d = SQ_SKIP;
          else begin
            nlen_d = LW'(byte_data);
            if (len_q != '0) st_d = SQ_MOLD;
            else if (byte_data == 8'd0) begin commit = 1'b1; st_d = SQ_IDLE; end
            else st_d = SQ_NEW1;
          end
        end
        SQ_MOLD: begin
          bad_d = bad_q | old_miss;
          if (last_old) begin
            idx_d = '0;
            if (nlen_q == '0) begin commit = !bad_d; st_d = SQ_IDLE; end
            else st_d = SQ_NEW1;
          end
        end
        SQ_NEW1: begin
          stage_we = 1'b1;
          if (last_new) begin idx_d = '0; st_d = SQ_NEW2; end
        end
        SQ_NEW2: begin
          bad_d = bad_q | cpy_miss;
          if (last_new) begin commit = !bad_d; st_d = SQ_IDLE; end
        end
        SQ_GRANT: begin
          bad_d = bad_q | old_miss;
          if (last_old) begin ev_ok = !bad_d; ev_fail = bad_d; st_d = SQ_IDLE; end
        end
        SQ_PTR: begin
          pacc_d = (pacc_q << 8) | PBW'(byte_data);
          if (last_ptr) begin ev_ptr = 1'b1; st_d = SQ_IDLE; end
        end
        default: idx_d = idx_q;
      endcase
    end
  end

  assign ptr_val = pacc_d[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; idx_q <= '0; bad_q <= 1'b0; nlen_q <= '0;
      pacc_q <= '0; len_q <= '0;
      for (int i = 0; i < MAX_LEN; i++) begin
        code_q[i]  <= '0;
        stage_q[i] <= '0;
      end
    end else begin
      st_q <= st_d; idx_q <= idx_d; bad_q <= bad_d; nlen_q <= nlen_d; pacc_q <= pacc_d;
      if (stage_we) stage_q[idx_q] <= byte_data;
      if (commit) begin
        len_q <= nlen_d;
        for (int i = 0; i < MAX_LEN; i++) code_q[i] <= stage_q[i];
      end
    end
  end
endmodule

// File: rtl/pg_flags.sv
module pg_flags
  import pg_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          frame_abort,
  input  logic          secure,
  input  logic          ev_ok,
  input  logic          ev_fail,
  input  logic          ev_ptr,
  input  logic [AW-1:0] ptr_val,
  input  logic          consume,
  output logic          acc_q,
  output logic          lock_q,
  output logic          pgm_q,
  output logic          ovr_q,
  output logic [AW-1:0] ptr_q
);
  logic          acc_d, lock_d, pgm_d, ovr_d;
  logic [AW-1:0] ptr_d;
  logic          cmd_go, may_ptr;

  assign cmd_go  = cmd_valid && !frame_abort;
  assign may_ptr = !secure || acc_q;

  always_comb begin
    acc_d = acc_q; lock_d = lock_q; pgm_d = pgm_q; ovr_d = ovr_q; ptr_d = ptr_q;
    if (consume) ovr_d = 1'b0;
    if (ev_ok) begin acc_d = 1'b1; lock_d = 1'b0; end
    if (ev_fail) acc_d = 1'b0;
    if (ev_ptr && may_ptr) ptr_d = ptr_val;
    if (cmd_go) begin
      case (op_e'(cmd_op))
        OP_LOCK:     begin acc_d = 1'b0; lock_d = 1'b1; ovr_d = 1'b0; end
        OP_OVERRIDE: if (may_ptr) ovr_d = 1'b1;
        OP_ARM:      pgm_d = 1'b1;
        OP_DISARM:   pgm_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0; lock_q <= 1'b0; pgm_q <= 1'b0; ovr_q <= 1'b0; ptr_q <= '0;
    end else begin
      acc_q <= acc_d; lock_q <= lock_d; pgm_q <= pgm_d; ovr_q <= ovr_d; ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/pg_decide.sv
module pg_decide
  import pg_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] ptr_q,
  input  logic          secure,
  input  logic          acc_q,
  input  logic          lock_q,
  input  logic          pgm_q,
  input  logic          ovr_q,
  output logic          allow
);
  logic below, keyed, prog_ok;

  assign below   = (req_addr < ptr_q);
  assign keyed   = !secure || acc_q;
  assign prog_ok = pgm_q && !lock_q && keyed;

  always_comb begin
    case (kind_e'(req_kind))
      AK_READ: allow = !below || keyed;
      AK_ONE:  allow = prog_ok && (!below || ovr_q);
      AK_BULK: allow = prog_ok;
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwd_guard.sv
module pwd_guard
  import pg_pkg::*;
#(
  parameter int AW      = 9,
  parameter int MAX_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_abort,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  input  logic          req_commit,
  output logic          req_allow
);
  localparam int LW = $clog2(MAX_LEN + 1);

  logic [1:0]    rst_pipe;
  logic          rst_sync;
  logic [LW-1:0] code_len;
  logic          secure, ev_ok, ev_fail, ev_ptr, consume;
  logic [AW-1:0] ptr_val, ptr_q;
  logic          acc_q, lock_q, pgm_q, ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  assign secure  = (code_len != '0);
  assign consume = req_commit && req_allow && (kind_e'(req_kind) == AK_ONE);

  pg_seq #(.AW(AW), .MAX_LEN(MAX_LEN)) u_seq (
    .clk(clk), .rst_n(rst_sync), .frame_abort(frame_abort),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .len_q(code_len), .ev_ok(ev_ok), .ev_fail(ev_fail),
    .ev_ptr(ev_ptr), .ptr_val(ptr_val)
  );

  pg_flags #(.AW(AW)) u_flags (
    .clk(clk), .rst_n(rst_sync), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .frame_abort(frame_abort), .secure(secure), .ev_ok(ev_ok), .ev_fail(ev_fail),
    .ev_ptr(ev_ptr), .ptr_val(ptr_val), .consume(consume),
    .acc_q(acc_q), .lock_q(lock_q), .pgm_q(pgm_q), .ovr_q(ovr_q), .ptr_q(ptr_q)
  );

  pg_decide #(.AW(AW)) u_decide (
    .req_addr(req_addr), .req_kind(req_kind), .ptr_q(ptr_q), .secure(secure),
    .acc_q(acc_q), .lock_q(lock_q), .pgm_q(pgm_q), .ovr_q(ovr_q),
    .allow(req_allow)
  );
endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          frame_abort,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_kind,
  input logic          req_commit,
  input logic          req_allow,
  input logic          secure,
  input logic [AW-1:0] ptr_q,
  input logic          acc_q,
  input logic          lock_q,
  input logic          pgm_q,
  input logic          ovr_q
);
  p_open_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure && req_kind == 2'd0) |-> req_allow);

  p_below_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure && req_kind == 2'd1 && req_addr < ptr_q && !ovr_q) |-> !req_allow);

  p_disarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_q && (req_kind == 2'd1 || req_kind == 2'd2)) |-> !req_allow);

  p_hidden_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (secure && !acc_q && req_addr < ptr_q) |-> !req_allow);

  p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && req_kind != 2'd0) |-> !req_allow);

  p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_commit && req_allow && req_kind == 2'd1 && !cmd_valid) |=> !ovr_q);

  p_abort_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_abort && !cmd_valid) |=> ($stable(acc_q) && $stable(pgm_q) && $stable(lock_q)));
endmodule

bind pwd_guard pg_guard_chk #(.AW(AW)) u_guard_chk (
  .clk(clk), .rst_n(rst_sync), .cmd_valid(cmd_valid), .frame_abort(frame_abort),
  .req_addr(req_addr), .req_kind(req_kind), .req_commit(req_commit),
  .req_allow(req_allow), .secure(secure), .ptr_q(ptr_q), .acc_q(acc_q),
  .lock_q(lock_q), .pgm_q(pgm_q), .ovr_q(ovr_q)
);

// File: tb/test_pwd_guard.sv
module test_pwd_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n, frame_abort, cmd_valid, byte_valid, req_commit, req_allow;
  logic [2:0]    cmd_op;
  logic [7:0]    byte_data;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_kind;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwd_guard #(.AW(AW), .MAX_LEN(8)) i_pwd_guard (
    .clk(clk), .rst_n(rst_n), .frame_abort(frame_abort), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .byte_valid(byte_valid), .byte_data(byte_data),
    .req_addr(req_addr), .req_kind(req_kind), .req_commit(req_commit),
    .req_allow(req_allow)
  );

  // monitor: pops the expectation pushed by the driver one half-cycle earlier
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (req_allow !== e) begin
        errors++;
        $display("FAIL %s: allow=%0b expected=%0b", t, req_allow, e);
      end
    end
  end

  task automatic quiet();
    frame_abort = 1'b0; cmd_valid = 1'b0; byte_valid = 1'b0;
    req_commit = 1'b0; req_kind = 2'd3;
  endtask

  task automatic cmd(input logic [2:0] op);
    @(posedge clk); #1; quiet(); cmd_valid = 1'b1; cmd_op = op;
  endtask

  task automatic put(input logic [7:0] b);
    @(posedge clk); #1; quiet(); byte_valid = 1'b1; byte_data = b;
  endtask

  task automatic abort_frame();
    @(posedge clk); #1; quiet(); frame_abort = 1'b1;
  endtask

  task automatic chk(input int addr, input logic [1:0] kind, input bit commit,
                     input bit exp, input string tag);
    @(posedge clk); #1; quiet();
    req_addr = AW'(addr); req_kind = kind; req_commit = commit;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: allow=x expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    quiet(); cmd_op = 3'd0; byte_data = 8'd0; req_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    chk(0,   2'd0, 0, 1, "R1 read 0 after reset");
    chk(300, 2'd0, 0, 1, "R1 read 300 after reset");
    chk(5,   2'd1, 0, 0, "R2 write while disarmed");
    cmd(3'd5);
    chk(5,   2'd1, 0, 1, "R1 write after arm, pointer 0");
    cmd(3'd3); put(8'h00); put(8'h80);             // pointer 128
    chk(100, 2'd1, 0, 0, "R3 write below pointer");
    chk(100, 2'd0, 0, 1, "R3 read below pointer");
    chk(128, 2'd1, 0, 1, "R3 write at pointer");
    chk(511, 2'd1, 0, 1, "R3 write top");
    chk(0,   2'd2, 0, 1, "R11 bulk ignores pointer");
    cmd(3'd4);
    chk(100, 2'd1, 1, 1, "R8 override write");
    chk(100, 2'd1, 0, 0, "R8 override spent");

    cmd(3'd0); put(8'd2); put(8'hAA); put(8'h55); put(8'hAA); put(8'h56);
    chk(200, 2'd1, 0, 1, "R4 mismatched copies rejected");
    chk(100, 2'd0, 0, 1, "R4 still open mode");
    cmd(3'd0); put(8'd9); put(8'd0); put(8'd1); put(8'hAA); put(8'hAA);
    chk(200, 2'd1, 0, 1, "R5 illegal length ignored");

    cmd(3'd0); put(8'd2); put(8'hAA); put(8'h55); put(8'hAA); put(8'h55);
    chk(100, 2'd0, 0, 0, "R6 secure low read hidden");
    chk(200, 2'd0, 0, 1, "R6 secure high read");
    chk(200, 2'd1, 0, 0, "R6 secure high write");
    chk(0,   2'd2, 0, 0, "R11 bulk needs access in secure");
    cmd(3'd4);                                     // override without access
    cmd(3'd3); put(8'h00); put(8'h10);             // pointer write without access
    cmd(3'd1); put(8'hAA); put(8'h56);
    chk(100, 2'd0, 0, 0, "R7 wrong code denied");
    cmd(3'd1); put(8'hAA); abort_frame();
    chk(100, 2'd0, 0, 0, "R12 abort mid grant");
    cmd(3'd1); put(8'hAA); put(8'h55);
    chk(100, 2'd0, 0, 1, "R6 low read after grant");
    chk(200, 2'd1, 0, 1, "R6 high write after grant");
    chk(50,  2'd1, 0, 0, "R9 pointer unmoved without access");
    chk(100, 2'd1, 0, 0, "R8 override ignored without access");
    abort_frame();
    chk(100, 2'd0, 0, 1, "R12 grant kept after abort");
    chk(200, 2'd1, 0, 1, "R12 arm kept after abort");
    cmd(3'd0); put(8'd2); put(8'hAA); abort_frame();

    cmd(3'd4);
    chk(50,  2'd1, 1, 1, "R8 override write secure");
    chk(50,  2'd1, 0, 0, "R8 override spent secure");
    cmd(3'd3); put(8'h00); put(8'h10);             // pointer 16
    chk(50,  2'd1, 0, 1, "R9 pointer moved with access");
    cmd(3'd2);
    chk(300, 2'd1, 0, 0, "R10 lock blocks write");
    chk(0,   2'd2, 0, 0, "R10 lock blocks bulk");
    chk(300, 2'd0, 0, 1, "R10 high read under lock");
    chk(5,   2'd0, 0, 0, "R10 lock withdraws access");

    cmd(3'd0); put(8'd1); put(8'hAA); put(8'h56); put(8'h33); put(8'h33);
    cmd(3'd1); put(8'hAA); put(8'h55);
    chk(5,   2'd0, 0, 1, "R4 wrong old code kept old code");
    chk(300, 2'd1, 0, 1, "R10 lock cleared by grant");

    cmd(3'd0); put(8'd0); put(8'hAA); put(8'h55);
    cmd(3'd2);
    chk(5,   2'd0, 0, 1, "R13 open mode again");
    cmd(3'd1);
    chk(300, 2'd1, 0, 1, "R13 open write after grant");
    cmd(3'd6);
    chk(300, 2'd1, 0, 0, "R2 disarmed write");
    chk(0,   2'd2, 0, 0, "R2 disarmed bulk");

    @(posedge clk); #1; quiet();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule